// File: doc/BRIEF.md
# Interrupt-Driven Byte UART

This block is a serial port for an 8-bit processor I/O bus. Software programs a 16-bit bit-period divisor through two byte registers. It starts a transmission by writing a byte to the data register, and collects received bytes by reading the same address. Frames use one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high.

The status register combines two kinds of bits. Two of them are live indicators: the transmitter can accept a byte, and an unread received byte is waiting. The other two are sticky event flags: a frame has finished going out, and a frame has come in. Software clears a flag by writing a one to its bit. The block drives a single interrupt request line, which stays high while either flag is set. The block also works with its serial output wired back to its serial input.

Top module: `uart_irq_port`

## Requirements
- R1: After reset the serial output is high, the interrupt line is low and the status register reads 0x01, meaning only TX ready (bit 0) is set.
- R2: The four registers sit at consecutive bus addresses from BASE_ADDR (default 80h): data at +0, status at +1, divisor low byte at +2 and divisor high byte at +3. Both divisor bytes read back what was written. Each serial bit lasts divisor+1 clock cycles.
- R3: Writing the data register while TX ready is set sends one frame: a low start bit, eight data bits least significant first, and a high stop bit. TX ready reads 0 while the frame is on the line.
- R4: A data register write while a frame is being sent is ignored, and no extra frame follows.
- R5: When the stop bit has been sent, the TX flag (status bit 4) is set and TX ready returns to 1.
- R6: The receiver samples each bit near its middle. A complete frame loads the received byte into the data register and sets both RX ready (bit 1) and the RX flag (bit 5). Reading the data register clears RX ready and leaves the RX flag set.
- R7: A low pulse on the serial input that has ended before the middle of the start bit is rejected. It changes no status bit.
- R8: A frame whose stop bit is sampled low is discarded. No status bit changes and the data register keeps its value.
- R9: A byte that completes while RX ready is still set replaces the old byte, and the RX flag stays set.
- R10: Writing a 1 to status bit 4 or bit 5 clears that flag. Writing 0 to either bit leaves it unchanged. The ready bits ignore status writes.
- R11: The interrupt line is high exactly when at least one of the two flags is set.
- R12: With the serial output wired to the serial input, each transmitted byte is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench writes the data register while a frame is still being sent. A transmitter that accepted that write would put a second, unexpected frame on the line or corrupt the frame already in progress. It also sends a short low glitch and a frame with a bad stop bit. A receiver that skipped the mid-start check or the stop-bit check would raise RX ready for data that never arrived. Further cases cover two bytes arriving back to back without a read, and status writes that carry zeros in the flag bits. A design that got these wrong would keep the old byte, or would clear a flag that software never acknowledged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int DATA_W = 8;
   localparam int DIV_W  = 16;

   // register offsets within the four-address window
   localparam logic [1:0] OFS_DATA = 2'd0;
   localparam logic [1:0] OFS_STAT = 2'd1;
   localparam logic [1:0] OFS_DIVL = 2'd2;
   localparam logic [1:0] OFS_DIVH = 2'd3;

   // status bit positions
   localparam int BIT_TXRDY = 0;
   localparam int BIT_RXRDY = 1;
   localparam int BIT_TXFLG = 4;
   localparam int BIT_RXFLG = 5;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
   import uart_irq_pkg::*;
#(
   parameter int CNT_W = DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  div,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   output logic              txd,
   output logic              busy,
   output logic              done
);
   localparam int FRAME_BITS = DATA_W + 2;
   localparam int BC_W       = $clog2(FRAME_BITS + 1);

   logic [FRAME_BITS-1:0] shreg;
   logic [BC_W-1:0]       bits_left;
   logic [CNT_W-1:0]      cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '1;
         bits_left <= '0;
         cnt       <= '0;
         busy      <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               shreg     <= {1'b1, data, 1'b0};
               bits_left <= BC_W'(FRAME_BITS);
               cnt       <= div;
               busy      <= 1'b1;
            end
         end else if (cnt == '0) begin
            cnt       <= div;
            shreg     <= {1'b1, shreg[FRAME_BITS-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == BC_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // ones are shifted in behind the frame, so the line rests high
   assign txd = shreg[0];

   // R4: a start request during a frame leaves the bit count alone
   p_busy_ignores_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cnt != '0) |=> $stable(bits_left));
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
   import uart_irq_pkg::*;
#(
   parameter int CNT_W       = DIV_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  div,
   input  logic              rxd,
   output logic              valid,
   output logic [DATA_W-1:0] byte_out
);
   localparam int BN_W = $clog2(DATA_W);

   logic rx_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], rxd};
         end
         assign rx_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [BN_W-1:0]   bitn;
   logic [DATA_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         sh       <= '0;
         valid    <= 1'b0;
         byte_out <= '0;
      end else begin
         valid <= 1'b0;
         case (st)
            RX_IDLE: if (!rx_s) begin
               cnt <= div >> 1;
               st  <= RX_START;
            end
            RX_START: if (cnt == '0) begin
               if (!rx_s) begin
                  cnt  <= div;
                  bitn <= '0;
                  st   <= RX_DATA;
               end else begin
                  st <= RX_IDLE;
               end
            end else cnt <= cnt - 1'b1;
            RX_DATA: if (cnt == '0) begin
               cnt <= div;
               sh  <= {rx_s, sh[DATA_W-1:1]};
               if (bitn == BN_W'(DATA_W-1)) st <= RX_STOP;
               else bitn <= bitn + 1'b1;
            end else cnt <= cnt - 1'b1;
            RX_STOP: if (cnt == '0) begin
               if (rx_s) begin
                  valid    <= 1'b1;
                  byte_out <= sh;
               end
               st <= RX_IDLE;
            end else cnt <= cnt - 1'b1;
            default: st <= RX_IDLE;
         endcase
      end
   end

   // R7: start bit gone high by mid-bit returns to idle
   p_glitch_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_START && cnt == '0 && rx_s) |=> (st == RX_IDLE && !valid));
   // R8: low stop bit yields no byte
   p_bad_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_STOP && cnt == '0 && !rx_s) |=> !valid);
endmodule

// File: rtl/uart_irq_port.sv
module uart_irq_port
   import uart_irq_pkg::*;
#(
   parameter logic [7:0]       BASE_ADDR   = 8'h80,
   parameter logic [DIV_W-1:0] RESET_DIV   = 16'd3,
   parameter int               SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   input  logic       bus_wr,
   input  logic       bus_rd,
   output logic [7:0] bus_rdata,
   input  logic       rxd,
   output logic       txd,
   output logic       irq
);
   localparam int DIVH_W = DIV_W - 8;

   initial begin
      if (BASE_ADDR[1:0] != 2'b00) $fatal(1, "BASE_ADDR must be aligned to four");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) $fatal(1, "SYNC_STAGES out of range");
   end

   logic       sel;
   logic [1:0] ofs;
   assign sel = (bus_addr[7:2] == BASE_ADDR[7:2]);
   assign ofs = bus_addr[1:0];

   logic wr_data, wr_stat, wr_divl, wr_divh, rd_data;
   assign wr_data = bus_wr && sel && ofs == OFS_DATA;
   assign wr_stat = bus_wr && sel && ofs == OFS_STAT;
   assign wr_divl = bus_wr && sel && ofs == OFS_DIVL;
   assign wr_divh = bus_wr && sel && ofs == OFS_DIVH;
   assign rd_data = bus_rd && sel && ofs == OFS_DATA;

   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] rx_byte, rx_new;
   logic              rx_ready, rx_flag, tx_flag;
   logic              tx_busy, tx_done, rx_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= RESET_DIV;
         rx_byte  <= '0;
         rx_ready <= 1'b0;
         rx_flag  <= 1'b0;
         tx_flag  <= 1'b0;
      end else begin
         if (wr_divl) div_q[7:0] <= bus_wdata;
         if (wr_divh) div_q[DIV_W-1:8] <= bus_wdata[DIVH_W-1:0];
         if (rx_valid) begin
            rx_byte  <= rx_new;
            rx_ready <= 1'b1;
         end else if (rd_data) begin
            rx_ready <= 1'b0;
         end
         // a fresh event wins over a clear in the same cycle
         if (rx_valid) rx_flag <= 1'b1;
         else if (wr_stat && bus_wdata[BIT_RXFLG]) rx_flag <= 1'b0;
         if (tx_done) tx_flag <= 1'b1;
         else if (wr_stat && bus_wdata[BIT_TXFLG]) tx_flag <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && sel) begin
         case (ofs)
            OFS_DATA: bus_rdata = rx_byte;
            OFS_STAT: begin
               bus_rdata[BIT_TXRDY] = !tx_busy;
               bus_rdata[BIT_RXRDY] = rx_ready;
               bus_rdata[BIT_TXFLG] = tx_flag;
               bus_rdata[BIT_RXFLG] = rx_flag;
            end
            OFS_DIVL: bus_rdata = div_q[7:0];
            default:  bus_rdata = 8'(div_q[DIV_W-1:8]);
         endcase
      end
   end

   assign irq = rx_flag | tx_flag;

   uart_tx_engine #(.CNT_W(DIV_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .div(div_q), .start(wr_data), .data(bus_wdata),
      .txd(txd), .busy(tx_busy), .done(tx_done)
   );

   uart_rx_engine #(.CNT_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .div(div_q), .rxd(rxd),
      .valid(rx_valid), .byte_out(rx_new)
   );

   // R6: a received byte raises both RX bits
   p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (rx_flag && rx_ready));
   // R5: end of frame raises the TX flag
   p_tx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> (tx_flag && !tx_busy));
   // R10: write-one clears the RX flag
   p_rx_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[BIT_RXFLG] && !rx_valid) |=> !rx_flag);
   // R10: without a write-one the RX flag holds
   p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag && !(wr_stat && bus_wdata[BIT_RXFLG])) |=> rx_flag);
   // R10: without a write-one the TX flag holds
   p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flag && !(wr_stat && bus_wdata[BIT_TXFLG])) |=> tx_flag);
endmodule

// File: tb/tb_uart_irq_port.sv
`timescale 1ns/1ps
module tb_uart_irq_port;
   localparam logic [7:0] A_DATA = 8'h80, A_STAT = 8'h81, A_DIVL = 8'h82, A_DIVH = 8'h83;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic rx_drv = 1'b1, loop = 1'b0;
   logic txd, irq, rxd;

   assign rxd = loop ? txd : rx_drv;
   always #2 clk = ~clk;

   uart_irq_port dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .rxd(rxd), .txd(txd), .irq(irq)
   );

   int compared = 0, mismatched = 0, frames = 0;
   int bit_ns = 16;
   bit finished = 1'b0;
   logic [7:0] exp_q[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic chk_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
      logic [7:0] v;
      bus_read(a, v);
      check(v === exp, req, v, exp);
   endtask

   // scoreboard driver: start a frame and record the expected byte
   task automatic send_tx(input logic [7:0] b);
      bus_write(A_DATA, b);
      exp_q.push_back(b);
   endtask

   task automatic wait_tx_idle();
      logic [7:0] v;
      for (int i = 0; i < 4000; i++) begin
         bus_read(A_STAT, v);
         if (v[0]) break;
      end
   endtask

   task automatic wait_rx_ready();
      logic [7:0] v;
      for (int i = 0; i < 4000; i++) begin
         bus_read(A_STAT, v);
         if (v[1]) break;
      end
   endtask

   task automatic drive_rx(input logic [7:0] b, input logic stop_bit);
      @(negedge clk);
      rx_drv = 1'b0; #(bit_ns);
      for (int i = 0; i < 8; i++) begin rx_drv = b[i]; #(bit_ns); end
      rx_drv = stop_bit; #(bit_ns);
      rx_drv = 1'b1; #(bit_ns * 2);
   endtask

   // monitor: decode frames on txd and compare with the queue
   initial begin
      logic [7:0] got;
      wait (rst_n);
      forever begin
         @(negedge txd);
         #(bit_ns / 2);
         check(txd === 1'b0, "R3 start bit", txd, 0);
         for (int i = 0; i < 8; i++) begin #(bit_ns); got[i] = txd; end
         #(bit_ns);
         check(txd === 1'b1, "R3 stop bit", txd, 1);
         frames++;
         if (exp_q.size() == 0) check(1'b0, "R4 unexpected frame", got, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(got === e, "R3 frame data", got, e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      #1 check(txd === 1'b1, "R1 txd idle", txd, 1);
      check(irq === 1'b0, "R1 irq low", irq, 0);
      rst_n = 1'b1;
      chk_reg(A_STAT, 8'h01, "R1 status");

      // R2: divisor 7 gives eight clocks (32 ns) per bit
      bus_write(A_DIVL, 8'h07);
      bus_write(A_DIVH, 8'h00);
      bit_ns = 32;
      chk_reg(A_DIVL, 8'h07, "R2 divisor low");
      chk_reg(A_DIVH, 8'h00, "R2 divisor high");

      // R3/R4: transmit, then try to overwrite mid-frame
      send_tx(8'hA5);
      chk_reg(A_STAT, 8'h00, "R3 tx busy");
      bus_write(A_DATA, 8'h3C);
      wait_tx_idle();
      chk_reg(A_STAT, 8'h11, "R5 tx flag and ready");
      #1 check(irq === 1'b1, "R11 irq on tx flag", irq, 1);
      #(bit_ns * 14);
      check(frames == 1, "R4 single frame", frames, 1);
      // R2: frame length measured from the bit period already checked by monitor

      // R10: write zero keeps, write one clears
      bus_write(A_STAT, 8'h00);
      chk_reg(A_STAT, 8'h11, "R10 zero write keeps flag");
      bus_write(A_STAT, 8'h10);
      chk_reg(A_STAT, 8'h01, "R10 tx flag cleared");
      #1 check(irq === 1'b0, "R11 irq low", irq, 0);

      // R6: receive
      drive_rx(8'h5A, 1'b1);
      chk_reg(A_STAT, 8'h23, "R6 rx ready and flag");
      #1 check(irq === 1'b1, "R11 irq on rx flag", irq, 1);
      chk_reg(A_DATA, 8'h5A, "R6 rx data");
      chk_reg(A_STAT, 8'h21, "R6 read clears ready only");
      bus_write(A_STAT, 8'h23);
      chk_reg(A_STAT, 8'h01, "R10 rx flag cleared, ready bits unchanged");

      // R9: overrun
      drive_rx(8'h11, 1'b1);
      drive_rx(8'h22, 1'b1);
      chk_reg(A_STAT, 8'h23, "R9 flag stays set");
      chk_reg(A_DATA, 8'h22, "R9 newest byte kept");
      bus_write(A_STAT, 8'h20);

      // R7: glitch shorter than half a bit
      @(negedge clk); rx_drv = 1'b0;
      repeat (2) @(negedge clk);
      rx_drv = 1'b1;
      #(bit_ns * 12);
      chk_reg(A_STAT, 8'h01, "R7 glitch ignored");

      // R8: bad stop bit
      drive_rx(8'h77, 1'b0);
      #(bit_ns * 12);
      chk_reg(A_STAT, 8'h01, "R8 bad frame dropped");
      chk_reg(A_DATA, 8'h22, "R8 data unchanged");

      // R12: loopback
      loop = 1'b1;
      #(bit_ns * 2);
      for (int k = 0; k < 3; k++) begin
         logic [7:0] b;
         b = 8'(8'hC3 ^ (k * 8'h5D));
         send_tx(b);
         wait_rx_ready();
         bus_read(A_DATA, v);
         check(v === b, "R12 loopback byte", v, b);
         bus_write(A_STAT, 8'h30);
      end
      #(bit_ns * 4);
      check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule